// File: doc/BRIEF.md
# Hamming 7/4 Single-Error-Correcting Codec

This block protects 4-bit values with a 7-bit even-parity Hamming code. Its encoder side takes a nibble and produces a codeword in which the three check bits sit at the power-of-two positions. Its decoder side takes a received word and recomputes the three checks to form a syndrome. The decoder inverts the bit that the syndrome names, whether that bit carries data or parity, and returns the repaired nibble with the syndrome and a flag that shows a repair was made.

Positions are numbered 7 down to 1 from left to right, and bit i-1 of a port vector holds position i. The syndrome, read as an unsigned binary number, is the position of a single flipped bit, and zero means no error. Each side has a valid-qualified input and output. Each side also has an optional output register stage, selected by a parameter. Both stages are on by default, which gives each side a latency of one cycle.

Top module: `ham74_codec`

## Requirements
- R1: The codeword places data bit 3 at position 7, bit 2 at position 6, bit 1 at position 5 and bit 0 at position 3. It places check bits at positions 4, 2 and 1. Each check bit makes even the count of ones over all positions whose index contains that power of two. For example, nibble 1101 encodes to 1100110 (positions 7 down to 1).
- R2: With the encoder stage enabled, enc_valid_o and enc_code_o reflect the enc_valid_i and enc_data_i of the previous rising clock edge.
- R3: While enc_valid_i is low, the encoder output codeword keeps its last value and enc_valid_o goes low.
- R4: Syndrome bit k is the even-parity check over all received positions whose index has bit k set. For a word with one flipped bit, the syndrome equals that bit's position (1..7).
- R5: With a zero syndrome, the decoded nibble is read unchanged from positions 7, 6, 5 and 3, and dec_corrected_o is low.
- R6: A single flipped data position is repaired. For example, 1110110 gives syndrome 101 and data 1101, with dec_corrected_o high.
- R7: A single flipped check position is repaired without changing the data. For example, 1100111 gives syndrome 001 and data 1101, with dec_corrected_o high.
- R8: With the decoder stage enabled, the decoder outputs appear one cycle after dec_valid_i. While dec_valid_i is low, dec_valid_o goes low and the data, syndrome and flag outputs keep their values.
- R9: During reset both output valids are low, and all data, codeword, syndrome and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | 4 | Nibble to encode |
| enc_valid_o | output | 1 | Encoder output qualifier |
| enc_code_o | output | 7 | Codeword, bit i-1 = position i |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | 7 | Received word, bit i-1 = position i |
| dec_valid_o | output | 1 | Decoder output qualifier |
| dec_data_o | output | 4 | Repaired nibble |
| dec_syndrome_o | output | 3 | Position of the flipped bit, 0 if none |
| dec_corrected_o | output | 1 | High when a bit was inverted |

## Verification
The bench drives every one of the 16 nibbles through the decoder both clean and with each of the seven single-bit flips. A swapped data-to-position mapping or a check bit with the wrong coverage therefore shows up as a wrong codeword or a wrong syndrome for at least one nibble. Flips in check positions are the trap for a decoder that repairs only data bits. Such a decoder would still report the right syndrome, so the bench also checks the nibble and the flag for those flips. Idle cycles with changed inputs catch an output register that loads without being qualified: its outputs would drift while valid is low.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned SYN_W  = 3;
  localparam int unsigned CODE_W = (1 << SYN_W) - 1;

  typedef logic [DATA_W-1:0] nib_t;
  typedef logic [CODE_W-1:0] cw_t;
  typedef logic [SYN_W-1:0]  syn_t;

  // data bit j sits at this 1-based position
  function automatic int unsigned data_pos(input int unsigned j);
    case (j)
      0:       data_pos = 3;
      1:       data_pos = 5;
      2:       data_pos = 6;
      default: data_pos = 7;
    endcase
  endfunction

  // even-parity check k over all positions whose index has bit k set
  function automatic syn_t calc_syndrome(input cw_t cw);
    syn_t s;
    s = '0;
    for (int unsigned k = 0; k < SYN_W; k++)
      for (int unsigned p = 1; p <= CODE_W; p++)
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ cw[p-1];
    return s;
  endfunction

  function automatic cw_t place_data(input nib_t d);
    cw_t c;
    c = '0;
    for (int unsigned j = 0; j < DATA_W; j++) c[data_pos(j)-1] = d[j];
    return c;
  endfunction

  function automatic nib_t take_data(input cw_t c);
    nib_t d;
    for (int unsigned j = 0; j < DATA_W; j++) d[j] = c[data_pos(j)-1];
    return d;
  endfunction

  function automatic cw_t encode(input nib_t d);
    cw_t  c;
    syn_t s;
    c = place_data(d);
    s = calc_syndrome(c);
    for (int unsigned k = 0; k < SYN_W; k++) c[(1 << k)-1] = s[k];
    return c;
  endfunction

  function automatic cw_t flip_mask(input syn_t s);
    cw_t m;
    m = '0;
    for (int unsigned p = 1; p <= CODE_W; p++)
      if (s == syn_t'(p)) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ham74_stage.sv
module ham74_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          dat_o <= '0;
        end else begin
          vld_o <= vld_i;
          if (vld_i) dat_o <= dat_i;
        end
      end
    end else begin : g_wire
      assign vld_o = vld_i;
      assign dat_o = dat_i;
    end
  endgenerate
endmodule

// File: rtl/ham74_encoder.sv
module ham74_encoder
  import ham74_pkg::*;
#(
  parameter bit REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  nib_t data_i,
  output logic vld_o,
  output cw_t  code_o
);
  cw_t code_c;
  assign code_c = encode(data_i);

  ham74_stage #(.W(CODE_W), .REG(REG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .vld_i(vld_i), .dat_i(code_c),
    .vld_o(vld_o), .dat_o(code_o)
  );
endmodule

// File: rtl/ham74_decoder.sv
module ham74_decoder
  import ham74_pkg::*;
#(
  parameter bit REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  cw_t  code_i,
  output logic vld_o,
  output nib_t data_o,
  output syn_t syn_o,
  output logic fixed_o,
  output syn_t syn_raw_o,
  output cw_t  mask_o
);
  localparam int unsigned PK_W = DATA_W + SYN_W + 1;

  cw_t         repaired;
  logic [PK_W-1:0] pk_c, pk_q;

  assign syn_raw_o = calc_syndrome(code_i);
  assign mask_o    = flip_mask(syn_raw_o);
  assign repaired  = code_i ^ mask_o;
  assign pk_c      = {take_data(repaired), syn_raw_o, |mask_o};

  ham74_stage #(.W(PK_W), .REG(REG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .vld_i(vld_i), .dat_i(pk_c),
    .vld_o(vld_o), .dat_o(pk_q)
  );

  assign data_o  = pk_q[PK_W-1 -: DATA_W];
  assign syn_o   = pk_q[SYN_W:1];
  assign fixed_o = pk_q[0];
endmodule

// File: rtl/ham74_codec.sv
module ham74_codec #(
  parameter bit ENC_REG = 1'b1,
  parameter bit DEC_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_valid_i,
  input  logic [3:0] enc_data_i,
  output logic       enc_valid_o,
  output logic [6:0] enc_code_o,
  input  logic       dec_valid_i,
  input  logic [6:0] dec_code_i,
  output logic       dec_valid_o,
  output logic [3:0] dec_data_o,
  output logic [2:0] dec_syndrome_o,
  output logic       dec_corrected_o
);
  // internal events brought out for the checker
  logic [2:0] dec_syn_raw;
  logic [6:0] dec_flip_mask;

  ham74_encoder #(.REG(ENC_REG)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .vld_i(enc_valid_i), .data_i(enc_data_i),
    .vld_o(enc_valid_o), .code_o(enc_code_o)
  );

  ham74_decoder #(.REG(DEC_REG)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .vld_i(dec_valid_i), .code_i(dec_code_i),
    .vld_o(dec_valid_o), .data_o(dec_data_o),
    .syn_o(dec_syndrome_o), .fixed_o(dec_corrected_o),
    .syn_raw_o(dec_syn_raw), .mask_o(dec_flip_mask)
  );
endmodule

// File: rtl/ham74_codec_chk.sv
module ham74_codec_chk #(
  parameter bit ENC_REG = 1'b1,
  parameter bit DEC_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_valid_i,
  input logic       enc_valid_o,
  input logic [6:0] enc_code_o,
  input logic       dec_valid_i,
  input logic       dec_valid_o,
  input logic [3:0] dec_data_o,
  input logic [2:0] dec_syndrome_o,
  input logic [2:0] dec_syn_raw,
  input logic [6:0] dec_flip_mask
);
  assert_enc_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_o |-> ham74_pkg::calc_syndrome(enc_code_o) == 3'd0);

  assert_flip_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_flip_mask));

  assert_flip_at_syn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_syn_raw != 3'd0) |-> dec_flip_mask[dec_syn_raw - 3'd1]);

  assert_no_flip_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_syn_raw == 3'd0) |-> (dec_flip_mask == 7'd0));

  generate
    if (ENC_REG) begin : g_enc
      assert_enc_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
      assert_enc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));
    end
    if (DEC_REG) begin : g_dec
      assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> (!dec_valid_o && $stable(dec_data_o) && $stable(dec_syndrome_o)));
    end
  endgenerate
endmodule

bind ham74_codec ham74_codec_chk #(.ENC_REG(ENC_REG), .DEC_REG(DEC_REG)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .enc_valid_i(enc_valid_i), .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
  .dec_valid_i(dec_valid_i), .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
  .dec_syndrome_o(dec_syndrome_o), .dec_syn_raw(dec_syn_raw),
  .dec_flip_mask(dec_flip_mask)
);

// File: tb/ham74_codec_bench.sv
module ham74_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid_i = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic       enc_valid_o;
  logic [6:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [6:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_corrected_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected codewords, index = nibble, bit i-1 = position i
  localparam logic [6:0] GOLD [16] = '{
    7'h00, 7'h07, 7'h19, 7'h1E, 7'h2A, 7'h2D, 7'h33, 7'h34,
    7'h4B, 7'h4C, 7'h52, 7'h55, 7'h61, 7'h66, 7'h78, 7'h7F
  };

  always #5 clk = ~clk;

  ham74_codec u_ham74_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_corrected_o(dec_corrected_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [6:0] held_code;
    logic [3:0] held_data;
    logic [2:0] held_syn;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 enc_valid", {7'd0, enc_valid_o}, 8'd0);
    check("R9 enc_code", {1'b0, enc_code_o}, 8'd0);
    check("R9 dec_valid", {7'd0, dec_valid_o}, 8'd0);
    check("R9 dec_out", {dec_data_o, dec_syndrome_o, dec_corrected_o}, 8'd0);
    rst_n = 1'b1;

    // table walk: all nibbles, clean and with each single flip
    for (int i = 0; i < 16; i++) begin
      for (int pos = 0; pos <= 7; pos++) begin
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = 4'(i);
        dec_valid_i = 1'b1;
        dec_code_i  = (pos == 0) ? GOLD[i] : (GOLD[i] ^ 7'(1 << (pos - 1)));
        @(negedge clk);
        check("R1 R2 codeword", {1'b0, enc_code_o}, {1'b0, GOLD[i]});
        check("R2 enc_valid", {7'd0, enc_valid_o}, 8'd1);
        check("R8 dec_valid", {7'd0, dec_valid_o}, 8'd1);
        check("R4 syndrome", {5'd0, dec_syndrome_o}, 8'(pos));
        if (pos == 0) begin
          check("R5 clean data", {4'd0, dec_data_o}, 8'(i));
          check("R5 flag low", {7'd0, dec_corrected_o}, 8'd0);
        end else if (pos == 1 || pos == 2 || pos == 4) begin
          check("R7 parity flip data", {4'd0, dec_data_o}, 8'(i));
          check("R7 flag", {7'd0, dec_corrected_o}, 8'd1);
        end else begin
          check("R6 data flip data", {4'd0, dec_data_o}, 8'(i));
          check("R6 flag", {7'd0, dec_corrected_o}, 8'd1);
        end
      end
    end

    // directed worked examples
    @(negedge clk);
    enc_data_i = 4'b1101; dec_code_i = 7'b1110110;
    @(negedge clk);
    check("R1 1101 encodes", {1'b0, enc_code_o}, 8'b01100110);
    check("R6 syndrome 101", {5'd0, dec_syndrome_o}, 8'd5);
    check("R6 data 1101", {4'd0, dec_data_o}, 8'b1101);
    dec_code_i = 7'b1100111;
    @(negedge clk);
    check("R7 syndrome 001", {5'd0, dec_syndrome_o}, 8'd1);
    check("R7 data 1101", {4'd0, dec_data_o}, 8'b1101);
    check("R7 flag", {7'd0, dec_corrected_o}, 8'd1);

    // idle with changed inputs: outputs must hold
    held_code = enc_code_o;
    held_data = dec_data_o;
    held_syn  = dec_syndrome_o;
    enc_valid_i = 1'b0; enc_data_i = 4'b0010;
    dec_valid_i = 1'b0; dec_code_i = 7'b0000001;
    @(negedge clk);
    @(negedge clk);
    check("R3 enc_valid low", {7'd0, enc_valid_o}, 8'd0);
    check("R3 code held", {1'b0, enc_code_o}, {1'b0, held_code});
    check("R8 dec_valid low", {7'd0, dec_valid_o}, 8'd0);
    check("R8 data held", {4'd0, dec_data_o}, {4'd0, held_data});
    check("R8 syndrome held", {5'd0, dec_syndrome_o}, {5'd0, held_syn});

    // reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset code", {1'b0, enc_code_o}, 8'd0);
    check("R9 re-reset dec", {dec_valid_o, dec_data_o, dec_syndrome_o}, 8'd0);

    done = 1'b1;
    finish_run();
  end
endmodule